// File: doc/BRIEF.md
# Watchdog Timer with Two-Key Stop Sequence

This block is a watchdog counter on a small register bus. It comes out of reset already running. It loads a reload value, counts up once per clock, and gives a one-cycle system-reset request each time it overflows. Software that wants the watchdog off writes an arming key and then a stop key into a control register. Each key write must wait until the previous write has gone through.

Every accepted control write is posted. The written word is held in a synchronisation stage for a fixed number of cycles, and only then does the key state machine act on it. During that window a status bit reports the write as pending, and further control writes are dropped. Once stopped, the counter freezes and the reset request stays low until the next reset.

Top module: `wdog_keyed_top`

## Requirements
- R1: After reset the watchdog runs from the reload value. The control register reads 0, the status register reads 0 and the reset request is low.
- R2: With no stop sequence, wdt_reset_req pulses high for exactly one cycle every PERIOD = 2^CNT_W - RELOAD cycles. The first pulse is visible after the PERIOD-th rising edge following the release of reset.
- R3: Two writes to byte offset 0x48 stop the watchdog. The first carries 0x0000AAAA and the second carries 0x00005555, and the second is issued only after the first is no longer pending.
- R4: A 0x00005555 write that is not immediately preceded by an accepted 0x0000AAAA write leaves the watchdog running.
- R5: Any accepted control value other than the two keys returns the key state machine to idle. A later 0x00005555 write then does not stop the watchdog.
- R6: The status register at byte offset 0x34 has the pending flag at bit 4 (mask 0x10), and every other bit reads 0. Bit 4 reads 1 in exactly SYNC_CYCLES=4 consecutive reads that follow an accepted control write.
- R7: A control write issued while the pending flag is set is ignored. It changes neither the control readback nor the key state.
- R8: Once stopped, the counter holds its value and wdt_reset_req stays low. The watchdog stays stopped whatever is written afterwards, until reset.
- R9: The control register reads back the last accepted value. Reads of unmapped offsets return 0, and read data is registered one cycle after the address.
- R10: bus_ready is high in the cycle after any cycle with bus_wr or bus_rd asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data for the address of the previous cycle |
| bus_ready | output | 1 | Access acknowledge, one cycle after the strobe |
| wdt_reset_req | output | 1 | One-cycle system-reset request on expiry |

## Verification
The assertions take for granted that reset is held from time zero and that RELOAD is below the counter's maximum, so expiry pulses are at least two cycles apart. They also assume that bus_wr only writes offsets the bus master means to write. The stimulus holds every strobe for exactly one cycle and changes inputs only on falling edges. It polls the pending flag before each key write, except in the scenarios that write into the pending window on purpose to show the write is dropped.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic {
    KEY_IDLE  = 1'b0,
    KEY_ARMED = 1'b1
  } key_state_e;

  localparam int unsigned OFS_CTRL  = 32'h48;
  localparam int unsigned OFS_STAT  = 32'h34;
  localparam int unsigned PEND_BIT  = 4;
  localparam int unsigned KEY_ARM   = 32'h0000_AAAA;
  localparam int unsigned KEY_STOP  = 32'h0000_5555;
endpackage

// File: rtl/wdog_post_sync.sv
module wdog_post_sync #(
  parameter int DATA_W      = 32,
  parameter int SYNC_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              commit,
  output logic [DATA_W-1:0] commit_data,
  output logic [DATA_W-1:0] shadow
);
  localparam int PEND_W = $clog2(SYNC_CYCLES + 1);
  localparam logic [PEND_W-1:0] PEND_LOAD = PEND_W'(SYNC_CYCLES);
  localparam logic [PEND_W-1:0] PEND_LAST = PEND_W'(1);

  logic [PEND_W-1:0] pend_q;
  logic              accept;

  assign busy        = (pend_q != '0);
  assign accept      = wr_req && !busy;
  assign commit      = (pend_q == PEND_LAST);
  assign commit_data = shadow;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      shadow <= '0;
    end else if (accept) begin
      pend_q <= PEND_LOAD;
      shadow <= wr_data;
    end else if (busy) begin
      pend_q <= pend_q - PEND_LAST;
    end
  end
endmodule

// File: rtl/wdog_key_fsm.sv
module wdog_key_fsm
  import wdog_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic [DATA_W-1:0] commit_data,
  output logic              run_en
);
  localparam logic [DATA_W-1:0] ARM_V  = DATA_W'(KEY_ARM);
  localparam logic [DATA_W-1:0] STOP_V = DATA_W'(KEY_STOP);

  key_state_e state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= KEY_IDLE;
      run_en  <= 1'b1;
    end else if (commit) begin
      if (commit_data == ARM_V) begin
        state_q <= KEY_ARMED;
      end else begin
        state_q <= KEY_IDLE;
        if (commit_data == STOP_V && state_q == KEY_ARMED) begin
          run_en <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W  = 16,
  parameter int RELOAD = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  localparam logic [CNT_W-1:0] RELOAD_V = CNT_W'(RELOAD);
  localparam logic [CNT_W-1:0] ONE_V    = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= RELOAD_V;
      expire <= 1'b0;
    end else if (run_en) begin
      if (&cnt) begin
        cnt    <= RELOAD_V;
        expire <= 1'b1;
      end else begin
        cnt    <= cnt + ONE_V;
        expire <= 1'b0;
      end
    end else begin
      expire <= 1'b0;
    end
  end
endmodule

// File: rtl/wdog_keyed_top.sv
module wdog_keyed_top
  import wdog_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 16,
  parameter int RELOAD      = 0,
  parameter int SYNC_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ready,
  output logic              wdt_reset_req
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(OFS_STAT);

  logic              ctrl_hit;
  logic              busy;
  logic              commit;
  logic [DATA_W-1:0] commit_data;
  logic [DATA_W-1:0] ctrl_shadow;
  logic              run_en;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] stat_word;

  assign ctrl_hit = bus_wr && (bus_addr == CTRL_A);

  wdog_post_sync #(.DATA_W(DATA_W), .SYNC_CYCLES(SYNC_CYCLES)) u_sync (
    .clk(clk), .rst(rst), .wr_req(ctrl_hit), .wr_data(bus_wdata),
    .busy(busy), .commit(commit), .commit_data(commit_data), .shadow(ctrl_shadow)
  );

  wdog_key_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst(rst), .commit(commit), .commit_data(commit_data), .run_en(run_en)
  );

  wdog_counter #(.CNT_W(CNT_W), .RELOAD(RELOAD)) u_cnt (
    .clk(clk), .rst(rst), .run_en(run_en), .cnt(cnt), .expire(wdt_reset_req)
  );

  always_comb begin
    stat_word           = '0;
    stat_word[PEND_BIT] = busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      bus_ready <= 1'b0;
    end else begin
      bus_ready <= bus_wr || bus_rd;
      if (bus_addr == CTRL_A)      bus_rdata <= ctrl_shadow;
      else if (bus_addr == STAT_A) bus_rdata <= stat_word;
      else                         bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/wdog_keyed_chk.sv
module wdog_keyed_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic              bus_ready,
  input logic              wdt_reset_req,
  input logic              run_en,
  input logic              busy,
  input logic [DATA_W-1:0] ctrl_shadow,
  input logic [CNT_W-1:0]  cnt
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(wdog_pkg::OFS_CTRL);

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    wdt_reset_req |=> !wdt_reset_req); // R2
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> !wdt_reset_req); // R8
  AST_OFF_STICKY: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> !run_en); // R8
  AST_OFF_HOLD: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> $stable(cnt)); // R8
  AST_PEND_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(bus_wr && bus_addr == CTRL_A)); // R6
  AST_DROP_BUSY_WR: assert property (@(posedge clk) disable iff (rst)
    (busy && bus_wr) |=> $stable(ctrl_shadow)); // R7
  AST_READY_ACK: assert property (@(posedge clk) disable iff (rst)
    (bus_wr || bus_rd) |=> bus_ready); // R10
endmodule

bind wdog_keyed_top wdog_keyed_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_ready(bus_ready), .wdt_reset_req(wdt_reset_req), .run_en(run_en),
  .busy(busy), .ctrl_shadow(ctrl_shadow), .cnt(cnt)
);

// File: tb/wdog_keyed_top_tb.sv
module wdog_keyed_top_tb;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 6;
  localparam int RELOAD = 48;
  localparam int SYNC   = 4;
  localparam int PERIOD = (1 << CNT_W) - RELOAD;
  localparam logic [ADDR_W-1:0] A_CTRL = 8'h48;
  localparam logic [ADDR_W-1:0] A_STAT = 8'h34;
  localparam logic [DATA_W-1:0] K1 = 32'h0000_AAAA;
  localparam logic [DATA_W-1:0] K2 = 32'h0000_5555;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_wr = 1'b0;
  logic              bus_rd = 1'b0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic              bus_ready;
  logic              wdt_reset_req;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  wdog_keyed_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
                   .RELOAD(RELOAD), .SYNC_CYCLES(SYNC)) u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .wdt_reset_req(wdt_reset_req)
  );

  task automatic check(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
    @(negedge clk);
    check("R10 ready after write", {31'b0, bus_ready}, 32'd1);
    bus_wr = 1'b0; bus_addr = A_STAT; bus_rd = 1'b1;
  endtask

  task automatic wait_clear(output int ones);
    ones = 0;
    bus_addr = A_STAT; bus_rd = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (bus_rdata[4]) ones++;
      else break;
    end
    bus_rd = 1'b0;
  endtask

  task automatic do_read(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic count_pulses(input int n, output int p);
    p = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (wdt_reset_req) p++;
    end
  endtask

  function automatic logic [DATA_W-1:0] val(input int i);
    case (i)
      0: return K1;
      1: return K2;
      2: return 32'h0;
      3: return 32'h0000_AAAB;
      default: return 32'h0001_5555;
    endcase
  endfunction

  initial begin : wdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [DATA_W-1:0] rd;
    int ones, p;

    // R1 reset state and R2 expiry timing
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    check("R1 req low at reset", {31'b0, wdt_reset_req}, 32'd0);
    for (int k = 1; k <= 2 * PERIOD + 1; k++) begin
      @(negedge clk);
      check("R2 pulse timing", {31'b0, wdt_reset_req},
            {31'b0, (k == PERIOD) || (k == 2 * PERIOD)});
    end
    do_reset();
    do_read(A_CTRL, rd); check("R1 ctrl reads 0", rd, 32'h0);
    do_read(A_STAT, rd); check("R1 status reads 0", rd, 32'h0);
    do_read(8'h00, rd);  check("R9 unmapped reads 0", rd, 32'h0);

    // R6 pending window and R9 readback
    do_reset();
    do_write(A_CTRL, 32'h1234_5678);
    check("R6 status other bits zero", bus_rdata & ~32'h10, 32'h0);
    wait_clear(ones);
    check("R6 pending cycles", ones, SYNC);
    do_read(A_CTRL, rd); check("R9 ctrl readback", rd, 32'h1234_5678);

    // R3/R4/R5 sweep over all ordered two-write sequences
    for (int i = 0; i < 5; i++) begin
      for (int j = 0; j < 5; j++) begin
        do_reset();
        do_write(A_CTRL, val(i)); wait_clear(ones);
        do_write(A_CTRL, val(j)); wait_clear(ones);
        count_pulses(2 * PERIOD, p);
        if (i == 0 && j == 1) check("R3 key pair stops", p, 0);
        else if (i == 0)      check("R5 other value disarms", {31'b0, p > 0}, 32'd1);
        else                  check("R4 stop without arm runs", {31'b0, p > 0}, 32'd1);
      end
    end

    // R5: arm, other value, stop key -> still running
    do_reset();
    do_write(A_CTRL, K1); wait_clear(ones);
    do_write(A_CTRL, 32'h0000_0001); wait_clear(ones);
    do_write(A_CTRL, K2); wait_clear(ones);
    count_pulses(2 * PERIOD, p);
    check("R5 disarmed by other value", {31'b0, p > 0}, 32'd1);

    // R7: write during pending dropped
    do_reset();
    do_write(A_CTRL, K1);
    do_write(A_CTRL, K2);
    wait_clear(ones);
    do_read(A_CTRL, rd); check("R7 dropped write readback", rd, K1);
    count_pulses(2 * PERIOD, p);
    check("R7 dropped stop key keeps running", {31'b0, p > 0}, 32'd1);
    do_write(A_CTRL, K2); wait_clear(ones);
    count_pulses(2 * PERIOD, p);
    check("R7 arm survived dropped write", p, 0);

    // R8: stays stopped after further writes; reset restores
    do_write(A_CTRL, 32'h0); wait_clear(ones);
    do_write(A_CTRL, K1); wait_clear(ones);
    count_pulses(3 * PERIOD, p);
    check("R8 stays stopped", p, 0);
    do_reset();
    count_pulses(2 * PERIOD, p);
    check("R1 reset restarts watchdog", p, 2);

    // R10 ready on read
    @(negedge clk);
    bus_addr = A_CTRL; bus_rd = 1'b1;
    @(negedge clk);
    check("R10 ready after read", {31'b0, bus_ready}, 32'd1);
    bus_rd = 1'b0;
    @(negedge clk);
    check("R10 ready drops", {31'b0, bus_ready}, 32'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule